// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Trapping and Wrapping Arithmetic

This block is the execute-stage datapath for a small load/store core. It is purely combinational: two operands, a shift distance and a four-bit operation code go in. A result word and a signed-overflow flag come out in the same cycle. The operations are bitwise AND, OR and NOR, three kinds of shift, add and subtract, two less-than comparisons, and placing a half-width constant in the upper half of a word.

Add and subtract each come in two forms. The checked form raises the overflow flag when the signed answer does not fit in the word. The wrapping form gives the answer modulo 2^W and never raises the flag. Less-than also comes in two forms: one treats the top bit as a sign, the other compares plain magnitudes. When the immediate select is high, the operand B is replaced by its low half-word, sign-extended to full width. The core's exception logic watches the overflow flag. Instruction decoding is done outside this block.

Top module: `int_alu`

## Requirements
- R1: Op 6 (checked add) returns (A+B) mod 2^W. It raises ovf exactly when A and B have the same sign and the sign of that sum differs from them.
- R2: Op 8 (checked subtract) returns (A-B) mod 2^W. It raises ovf exactly when A and B differ in sign and the sign of that difference differs from A.
- R3: Op 7 (wrapping add) and op 9 (wrapping subtract) return the same results modulo 2^W, with ovf held at 0. For example, 1 + 0xFFFFFFFF gives 0.
- R4: Op 10 returns 1 when A < B as two's-complement numbers (bit W-1 is the sign), and 0 otherwise. All higher result bits are 0.
- R5: Op 11 returns 1 when A < B as unsigned magnitudes, and 0 otherwise. All higher result bits are 0.
- R6: Op 3 shifts A left by shamt and op 4 shifts A right by shamt. Both fill the vacated bits with zeros.
- R7: Op 5 shifts A right by shamt and fills the vacated bits with copies of A[W-1]. For example, -25 shifted by 4 gives -2.
- R8: Op 0 returns A AND B, op 1 returns A OR B, and op 2 returns NOT (A OR B). NOR against a zero operand gives NOT A.
- R9: Op 12 places B[15:0] in result bits W-1..W-16 and clears the bits below them.
- R10: When b_imm is 1, every operation except op 12 uses the sign-extension of B[15:0] in place of B.
- R11: ovf is 0 for every op other than 6 and 8.
- R12: Ops 13, 14 and 15 return a result of 0 with ovf at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (see requirements) |
| a | input | W | First operand; also the value that is shifted |
| b | input | W | Second operand; its low 16 bits are the immediate |
| shamt | input | log2(W) | Shift distance |
| b_imm | input | 1 | Replace B with the sign-extended B[15:0] |
| result | output | W | Operation result |
| ovf | output | 1 | Signed overflow from a checked add or subtract |

## Verification
The bench builds the block with its default values: a 32-bit word and a 16-bit immediate. At this width the reference functions can compute each sum on 33 bits and compare the carry into the extra bit, which detects overflow in a different way from the RTL. The five-bit shift field lets random stimulus cover every shift distance from 0 to 31. Directed vectors reach the most-positive and most-negative boundaries, the wrap past all-ones, and immediates with bit 15 set.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  localparam int SH_W = $clog2(W)
) (
  input  logic [3:0]      op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [SH_W-1:0] shamt,
  input  logic            b_imm,
  output logic [W-1:0]    result,
  output logic            ovf
);
  localparam logic [3:0] OP_AND  = 4'd0;
  localparam logic [3:0] OP_OR   = 4'd1;
  localparam logic [3:0] OP_NOR  = 4'd2;
  localparam logic [3:0] OP_SLL  = 4'd3;
  localparam logic [3:0] OP_SRL  = 4'd4;
  localparam logic [3:0] OP_SRA  = 4'd5;
  localparam logic [3:0] OP_ADD  = 4'd6;
  localparam logic [3:0] OP_ADDU = 4'd7;
  localparam logic [3:0] OP_SUB  = 4'd8;
  localparam logic [3:0] OP_SUBU = 4'd9;
  localparam logic [3:0] OP_SLT  = 4'd10;
  localparam logic [3:0] OP_SLTU = 4'd11;
  localparam logic [3:0] OP_UPI  = 4'd12;

  logic [W-1:0] bx, sum, diff;
  logic         add_ovf, sub_ovf, lt_s, lt_u;

  assign bx   = b_imm ? {{(W-IMM_W){b[IMM_W-1]}}, b[IMM_W-1:0]} : b;
  assign sum  = a + bx;
  assign diff = a - bx;

  assign add_ovf = (a[W-1] ~^ bx[W-1]) & (sum[W-1] ^ a[W-1]);
  assign sub_ovf = (a[W-1] ^ bx[W-1]) & (diff[W-1] ^ a[W-1]);
  assign lt_u    = a < bx;
  assign lt_s    = (a[W-1] ^ bx[W-1]) ? a[W-1] : diff[W-1];

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (op)
      OP_AND:  result = a & bx;
      OP_OR:   result = a | bx;
      OP_NOR:  result = ~(a | bx);
      OP_SLL:  result = a << shamt;
      OP_SRL:  result = a >> shamt;
      OP_SRA:  result = $unsigned($signed(a) >>> shamt);
      OP_ADD:  begin result = sum;  ovf = add_ovf; end
      OP_ADDU: result = sum;
      OP_SUB:  begin result = diff; ovf = sub_ovf; end
      OP_SUBU: result = diff;
      OP_SLT:  result = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(W-1){1'b0}}, lt_u};
      OP_UPI:  result = {b[IMM_W-1:0], {(W-IMM_W){1'b0}}};
      default: result = '0;
    endcase
  end

  always_comb begin
    // R11
    flag_scope_chk: assert (!ovf || op == OP_ADD || op == OP_SUB)
      else $error("ovf raised for op %0d", op);
    // R3
    wrap_no_flag_chk: assert (!((op == OP_ADDU || op == OP_SUBU) && ovf))
      else $error("wrapping op raised ovf");
    // R1
    add_ovf_chk: assert (!(op == OP_ADD && a[W-1] == bx[W-1] && result[W-1] != a[W-1]) || ovf)
      else $error("checked add missed overflow");
    // R4
    slt_width_chk: assert (!(op == OP_SLT || op == OP_SLTU) || result[W-1:1] == '0)
      else $error("compare result wider than one bit");
    // R9
    upi_low_chk: assert (op != OP_UPI || result[W-IMM_W-1:0] == '0)
      else $error("upper-immediate low bits not clear");
    // R12
    unused_op_chk: assert (op <= OP_UPI || (result == '0 && !ovf))
      else $error("unused op produced output");
  end
endmodule

// File: tb/test_int_alu.sv
module test_int_alu;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  op;
  logic [31:0] a, b, result;
  logic [4:0]  shamt;
  logic        b_imm, ovf;
  int errors = 0;
  int checks = 0;

  int_alu i_int_alu (.op(op), .a(a), .b(b), .shamt(shamt), .b_imm(b_imm),
                     .result(result), .ovf(ovf));

  function automatic string tag(input logic [3:0] o, input logic im);
    if (im && o != 4'd12) return "R10";
    case (o)
      4'd0, 4'd1, 4'd2: return "R8";
      4'd3, 4'd4:       return "R6";
      4'd5:             return "R7";
      4'd6:             return "R1";
      4'd8:             return "R2";
      4'd7, 4'd9:       return "R3";
      4'd10:            return "R4";
      4'd11:            return "R5";
      4'd12:            return "R9";
      default:          return "R12";
    endcase
  endfunction

  function automatic logic [32:0] model(input logic [3:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic [4:0] s,
                                        input logic im);
    logic [31:0] yy;
    logic [32:0] w;
    yy = im ? {{16{y[15]}}, y[15:0]} : y;
    case (o)
      4'd0: return {1'b0, x & yy};
      4'd1: return {1'b0, x | yy};
      4'd2: return {1'b0, ~(x | yy)};
      4'd3: return {1'b0, x << s};
      4'd4: return {1'b0, x >> s};
      4'd5: return {1'b0, 32'($signed(x) >>> s)};
      4'd6, 4'd7: begin
        w = {x[31], x} + {yy[31], yy};
        return {(o == 4'd6) && (w[32] != w[31]), w[31:0]};
      end
      4'd8, 4'd9: begin
        w = {x[31], x} - {yy[31], yy};
        return {(o == 4'd8) && (w[32] != w[31]), w[31:0]};
      end
      4'd10: return {1'b0, 31'd0, $signed(x) < $signed(yy)};
      4'd11: return {1'b0, 31'd0, x < yy};
      4'd12: return {1'b0, y[15:0], 16'h0000};
      default: return 33'd0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [4:0] s, input logic im);
    logic [32:0] exp;
    @(negedge clk);
    op = o; a = x; b = y; shamt = s; b_imm = im;
    #1;
    exp = model(o, x, y, s, im);
    checks++;
    if ({ovf, result} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d imm=%0b: got ovf=%0b res=%h, expected ovf=%0b res=%h",
               tag(o, im), o, x, y, s, im, ovf, result, exp[32], exp[31:0]);
    end
  endtask

  task automatic expect_val(input string r, input logic [31:0] er, input logic eo);
    checks++;
    if (result !== er || ovf !== eo) begin
      errors++;
      $display("FAIL %s: got res=%h ovf=%0b, expected res=%h ovf=%0b", r, result, ovf, er, eo);
    end
  endtask

  initial begin
    op = 0; a = 0; b = 0; shamt = 0; b_imm = 0;
    #1;
    expect_val("R8", 32'h0, 1'b0);
    apply(4'd6, 32'h1, 32'h7FFF_FFFF, 0, 0); expect_val("R1", 32'h8000_0000, 1'b1);
    apply(4'd6, 32'h8000_0000, 32'h8000_0000, 0, 0); expect_val("R1", 32'h0, 1'b1);
    apply(4'd6, 32'hFFFF_FFFF, 32'h1, 0, 0); expect_val("R1", 32'h0, 1'b0);
    apply(4'd8, 32'h8000_0000, 32'h1, 0, 0); expect_val("R2", 32'h7FFF_FFFF, 1'b1);
    apply(4'd8, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0); expect_val("R2", 32'h8000_0000, 1'b1);
    apply(4'd7, 32'h1, 32'hFFFF_FFFF, 0, 0); expect_val("R3", 32'h0, 1'b0);
    apply(4'd9, 32'h8000_0000, 32'h1, 0, 0); expect_val("R3", 32'h7FFF_FFFF, 1'b0);
    apply(4'd10, 32'hFFFF_FFFF, 32'h1, 0, 0); expect_val("R4", 32'h1, 1'b0);
    apply(4'd11, 32'hFFFF_FFFF, 32'h1, 0, 0); expect_val("R5", 32'h0, 1'b0);
    apply(4'd5, 32'hFFFF_FFE7, 32'h0, 5'd4, 0); expect_val("R7", 32'hFFFF_FFFE, 1'b0);
    apply(4'd4, 32'h8000_0000, 32'h0, 5'd31, 0); expect_val("R6", 32'h1, 1'b0);
    apply(4'd3, 32'h9, 32'h0, 5'd4, 0); expect_val("R6", 32'h90, 1'b0);
    apply(4'd2, 32'h0000_3C00, 32'h0, 0, 0); expect_val("R8", 32'hFFFF_C3FF, 1'b0);
    apply(4'd12, 32'h0, 32'hABCD_003D, 0, 1); expect_val("R9", 32'h003D_0000, 1'b0);
    apply(4'd7, 32'h10, 32'h0000_FFFF, 0, 1); expect_val("R10", 32'hF, 1'b0);
    apply(4'd10, 32'h0, 32'h0000_8000, 0, 1); expect_val("R10", 32'h0, 1'b0);
    apply(4'd1, 32'h0, 32'h1234_8001, 0, 1); expect_val("R10", 32'hFFFF_8001, 1'b0);
    apply(4'd0, 32'h1, 32'h1, 0, 0); expect_val("R11", 32'h1, 1'b0);
    for (int o = 13; o < 16; o++) begin
      apply(4'(o), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 0); expect_val("R12", 32'h0, 1'b0);
    end
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] x, y;
      x = $urandom();
      y = $urandom();
      if (i % 7 == 0) x = {x[31], {31{~x[31]}}};
      if (i % 11 == 0) y = {y[31], {31{~y[31]}}};
      apply(4'($urandom_range(0, 15)), x, y, 5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule